// File: doc/BRIEF.md
# Multi-mode 16-bit PWM timer

This block is a 16-bit up-counter that drives two compare channels and runs in one of three counting styles. A 4-bit mode code selects the style. In free-running mode the counter wraps through its full range. In clear-on-match mode (CTC) the counter returns to zero after it equals a TOP value. In single-slope fast PWM the counter ramps from zero to TOP and restarts.

TOP is either a fixed constant or the content of one of two registers. Those are the compare A register and the capture/TOP register. A prescaler outside the block supplies a one-cycle enable, and the counter advances only on enabled cycles. Software-side logic writes the counter, the compare registers and the capture/TOP register through direct write strobes.

The outputs are these:
- the counter value;
- the active compare values;
- match strobes for A and B, and a BOTTOM strobe;
- three sticky event flags, cleared by writing ones.

In fast PWM the compare A register is double-buffered so that the period and the duty cycle can be changed without glitches. In CTC it is written directly, so a late write can make the counter miss its match.

Top module: `pwm_timer16`

## Requirements
- R1: After reset the counter, both active compare values, the capture/TOP register and all flags are zero.
- R2: The counter changes only in cycles where `tick_en` is high or `cnt_wr` is high. Match and bottom strobes are raised only in cycles with `tick_en` high.
- R3: Mode 0x0 and the reserved codes 0x1, 0x2, 0x3, 0x8, 0x9, 0xA, 0xB and 0xD count up with no clear. The counter wraps from 0xFFFF to 0x0000, and `flags[0]` (overflow) sets on the same edge at which the count becomes zero.
- R4: Mode 0x4 clears the counter to zero on the enabled edge after the count equals active compare A. The `match_a` strobe and `flags[1]` (compare A) mark that cycle.
- R5: Mode 0xC clears the counter on the enabled edge after the count equals the capture/TOP register, and sets `flags[2]` (capture) on that edge.
- R6: In CTC modes the overflow flag sets only when the count passes 0xFFFF. A compare A write is applied at once, so a new TOP below the current count lets the counter run through 0xFFFF and wrap before any match.
- R7: Modes 0x5, 0x6 and 0x7 are fast PWM with TOP = 0x00FF, 0x01FF and 0x03FF. The counter clears on the enabled edge after it equals TOP, and the overflow flag sets on that same edge.
- R8: Mode 0xE takes TOP from the capture/TOP register and mode 0xF takes it from active compare A. On the TOP edge the capture flag (0xE) or the compare A flag (0xF) sets together with the overflow flag.
- R9: In fast PWM modes (0x5, 0x6, 0x7, 0xE, 0xF) a compare A write goes to a buffer. Active compare A (`cmp_a_q`) loads from the buffer only on the enabled edge where the count equals TOP. The capture/TOP register is always written directly.
- R10: In modes 0x5, 0x6 and 0x7, written compare A and compare B values are ANDed with that mode's TOP, so the bits above it are forced to zero.
- R11: A counter write loads `cnt_wdata` regardless of `tick_en`, and takes priority over counting and clearing. In that cycle it suppresses the match and bottom strobes and all flag-setting events.
- R12: Flags are sticky and clear when a one is written to the matching `flag_clr` bit. A set event in the same cycle wins over the clear.
- R13: `match_b` is high in an enabled cycle where the count equals compare B. `bottom` is high in an enabled cycle where the count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable from the external prescaler |
| mode_sel | input | 4 | Waveform mode code |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmpa_wr | input | 1 | Compare A write strobe |
| cmpa_wdata | input | 16 | Compare A write value |
| cmpb_wr | input | 1 | Compare B write strobe |
| cmpb_wdata | input | 16 | Compare B write value |
| capt_wr | input | 1 | Capture/TOP register write strobe |
| capt_wdata | input | 16 | Capture/TOP register write value |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| count | output | 16 | Current counter value |
| cmp_a_q | output | 16 | Active compare A value |
| cmp_b_q | output | 16 | Compare B value |
| match_a | output | 1 | Compare A match strobe |
| match_b | output | 1 | Compare B match strobe |
| bottom | output | 1 | Counter-at-zero strobe |
| flags | output | 3 | Sticky flags: [0] overflow, [1] compare A, [2] capture |

## Verification
A wrong TOP selection or a wrong clear decision shows on `count` in the first enabled cycle after the count reaches the intended TOP. From then on every later cycle differs.

A buffer that loads at the wrong time shows on `cmp_a_q` at once. It shows on `match_a` as soon as the count passes the wrongly loaded value.

Flag and strobe errors are visible in the same cycle or on the next edge. The reference model is compared on every clock, so the first divergent cycle is reported.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   typedef enum logic [1:0] {
      KIND_FREE  = 2'd0,
      KIND_CLEAR = 2'd1,
      KIND_SLOPE = 2'd2
   } run_kind_e;

   typedef enum logic [2:0] {
      TSEL_MAX  = 3'd0,
      TSEL_8B   = 3'd1,
      TSEL_9B   = 3'd2,
      TSEL_10B  = 3'd3,
      TSEL_CMPA = 3'd4,
      TSEL_CAPT = 3'd5
   } top_sel_e;

   typedef struct packed {
      run_kind_e kind;
      top_sel_e  tsel;
   } mode_cfg_t;

   localparam int FLAG_OVF  = 0;
   localparam int FLAG_CMPA = 1;
   localparam int FLAG_CAPT = 2;
   localparam int NUM_FLAGS = 3;
   localparam int NUM_CMP   = 2;

   function automatic mode_cfg_t decode_mode(input logic [3:0] code);
      mode_cfg_t c;
      case (code)
         4'h4:    c = '{kind: KIND_CLEAR, tsel: TSEL_CMPA};
         4'hC:    c = '{kind: KIND_CLEAR, tsel: TSEL_CAPT};
         4'h5:    c = '{kind: KIND_SLOPE, tsel: TSEL_8B};
         4'h6:    c = '{kind: KIND_SLOPE, tsel: TSEL_9B};
         4'h7:    c = '{kind: KIND_SLOPE, tsel: TSEL_10B};
         4'hE:    c = '{kind: KIND_SLOPE, tsel: TSEL_CAPT};
         4'hF:    c = '{kind: KIND_SLOPE, tsel: TSEL_CMPA};
         default: c = '{kind: KIND_FREE,  tsel: TSEL_MAX};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pwm_mode_decode.sv
module pwm_mode_decode
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [3:0]       mode_code,
   input  logic [CNT_W-1:0] cmpa_val,
   input  logic [CNT_W-1:0] capt_val,
   output run_kind_e        kind,
   output top_sel_e         tsel,
   output logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] wr_mask
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] TOP_8B   = CNT_W'(32'h0000_00FF);
   localparam logic [CNT_W-1:0] TOP_9B   = CNT_W'(32'h0000_01FF);
   localparam logic [CNT_W-1:0] TOP_10B  = CNT_W'(32'h0000_03FF);

   mode_cfg_t cfg;
   logic      fixed_top;

   assign cfg  = decode_mode(mode_code);
   assign kind = cfg.kind;
   assign tsel = cfg.tsel;

   always_comb begin
      fixed_top = 1'b0;
      case (cfg.tsel)
         TSEL_8B:   begin top_val = TOP_8B;  fixed_top = 1'b1; end
         TSEL_9B:   begin top_val = TOP_9B;  fixed_top = 1'b1; end
         TSEL_10B:  begin top_val = TOP_10B; fixed_top = 1'b1; end
         TSEL_CMPA: top_val = cmpa_val;
         TSEL_CAPT: top_val = capt_val;
         default:   top_val = ALL_ONES;
      endcase
      wr_mask = fixed_top ? top_val : ALL_ONES;
   end

endmodule

// File: rtl/pwm_compare_bank.sv
module pwm_compare_bank #(
   parameter int CNT_W = 16,
   parameter bit BUF_A = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slope_mode,
   input  logic [CNT_W-1:0] wr_mask,
   input  logic             reload,
   input  logic             a_wr,
   input  logic [CNT_W-1:0] a_data,
   input  logic             b_wr,
   input  logic [CNT_W-1:0] b_data,
   input  logic             c_wr,
   input  logic [CNT_W-1:0] c_data,
   output logic [CNT_W-1:0] a_act,
   output logic [CNT_W-1:0] b_q,
   output logic [CNT_W-1:0] c_q
);

   logic [CNT_W-1:0] a_val;
   logic [CNT_W-1:0] b_val;

   assign a_val = a_data & wr_mask;
   assign b_val = b_data & wr_mask;

   generate
      if (BUF_A) begin : g_buffered
         logic [CNT_W-1:0] a_buf;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    a_buf <= '0;
            else if (a_wr) a_buf <= a_val;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   a_act <= '0;
            else if (a_wr && !slope_mode) a_act <= a_val;
            else if (reload)              a_act <= a_buf;
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    a_act <= '0;
            else if (a_wr) a_act <= a_val;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (b_wr) b_q <= b_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    c_q <= '0;
      else if (c_wr) c_q <= c_data;
   end

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clear_at_top,
   input  logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] cnt,
   output logic             adv,
   output logic             top_hit,
   output logic             max_hit
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_next;

   assign adv     = tick_en & ~load;
   assign top_hit = adv & (cnt == top_val);
   assign max_hit = adv & (cnt == CNT_MAX);

   always_comb begin
      if (load)                         cnt_next = load_val;
      else if (!tick_en)                cnt_next = cnt;
      else if (clear_at_top && top_hit) cnt_next = '0;
      else                              cnt_next = cnt + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_next;
   end

endmodule

// File: rtl/pwm_event_flags.sv
module pwm_event_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_ev,
   input  logic [N-1:0] clr_req,
   output logic [N-1:0] flag_q
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (set_ev[i])  flag_q[i] <= 1'b1;
            else if (clr_req[i]) flag_q[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter bit BUF_A = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [3:0]       mode_sel,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             cmpa_wr,
   input  logic [CNT_W-1:0] cmpa_wdata,
   input  logic             cmpb_wr,
   input  logic [CNT_W-1:0] cmpb_wdata,
   input  logic             capt_wr,
   input  logic [CNT_W-1:0] capt_wdata,
   input  logic [2:0]       flag_clr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cmp_a_q,
   output logic [CNT_W-1:0] cmp_b_q,
   output logic             match_a,
   output logic             match_b,
   output logic             bottom,
   output logic [2:0]       flags
);

   generate
      if (CNT_W < 10 || CNT_W > 32) begin : g_bad_width
         $error("pwm_timer16: CNT_W must lie in 10..32");
      end
      if (NUM_FLAGS != 3) begin : g_bad_flags
         $error("pwm_timer16: flag vector width mismatch");
      end
   endgenerate

   run_kind_e        kind;
   top_sel_e         tsel;
   logic [CNT_W-1:0] top_val;
   logic [CNT_W-1:0] wr_mask;
   logic [CNT_W-1:0] capt_q;
   logic             adv;
   logic             top_hit;
   logic             max_hit;
   logic             slope_mode;
   logic             reload;
   logic [NUM_CMP-1:0]   cmp_hit;
   logic [CNT_W-1:0]     cmp_val [NUM_CMP];
   logic [NUM_FLAGS-1:0] flag_set;

   pwm_mode_decode #(.CNT_W(CNT_W)) u_dec (
      .mode_code (mode_sel),
      .cmpa_val  (cmp_a_q),
      .capt_val  (capt_q),
      .kind      (kind),
      .tsel      (tsel),
      .top_val   (top_val),
      .wr_mask   (wr_mask)
   );

   assign slope_mode = (kind == KIND_SLOPE);
   assign reload     = top_hit & slope_mode;

   pwm_compare_bank #(.CNT_W(CNT_W), .BUF_A(BUF_A)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .slope_mode (slope_mode),
      .wr_mask    (wr_mask),
      .reload     (reload),
      .a_wr       (cmpa_wr),
      .a_data     (cmpa_wdata),
      .b_wr       (cmpb_wr),
      .b_data     (cmpb_wdata),
      .c_wr       (capt_wr),
      .c_data     (capt_wdata),
      .a_act      (cmp_a_q),
      .b_q        (cmp_b_q),
      .c_q        (capt_q)
   );

   pwm_count_core #(.CNT_W(CNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .load         (cnt_wr),
      .load_val     (cnt_wdata),
      .clear_at_top (kind != KIND_FREE),
      .top_val      (top_val),
      .cnt          (count),
      .adv          (adv),
      .top_hit      (top_hit),
      .max_hit      (max_hit)
   );

   assign cmp_val[0] = cmp_a_q;
   assign cmp_val[1] = cmp_b_q;

   generate
      for (genvar c = 0; c < NUM_CMP; c++) begin : g_match
         assign cmp_hit[c] = adv & (count == cmp_val[c]);
      end
   endgenerate

   assign match_a = cmp_hit[0];
   assign match_b = cmp_hit[1];
   assign bottom  = adv & (count == '0);

   assign flag_set[FLAG_OVF]  = slope_mode ? top_hit : max_hit;
   assign flag_set[FLAG_CMPA] = cmp_hit[0];
   assign flag_set[FLAG_CAPT] = top_hit & (tsel == TSEL_CAPT);

   pwm_event_flags #(.N(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (flag_set),
      .clr_req (flag_clr),
      .flag_q  (flags)
   );

endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic [3:0]       mode_sel,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic             cmpa_wr,
   input logic [CNT_W-1:0] cmpa_wdata,
   input logic             cmpb_wr,
   input logic [CNT_W-1:0] cmpb_wdata,
   input logic             capt_wr,
   input logic [CNT_W-1:0] capt_wdata,
   input logic [2:0]       flag_clr,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp_a_q,
   input logic [CNT_W-1:0] cmp_b_q,
   input logic             match_a,
   input logic             match_b,
   input logic             bottom,
   input logic [2:0]       flags
);

   logic             known_top_pwm;
   logic [CNT_W-1:0] chk_top;
   logic             free_code;
   logic [2:0]       kept;

   always_comb begin
      known_top_pwm = 1'b1;
      case (mode_sel)
         4'h5:    chk_top = CNT_W'(32'hFF);
         4'h6:    chk_top = CNT_W'(32'h1FF);
         4'h7:    chk_top = CNT_W'(32'h3FF);
         4'hF:    chk_top = cmp_a_q;
         default: begin chk_top = '0; known_top_pwm = 1'b0; end
      endcase
   end

   assign free_code = !(mode_sel inside {4'h4, 4'hC, 4'h5, 4'h6, 4'h7, 4'hE, 4'hF});
   assign kept      = flags & ~flag_clr;

   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (count == '0 && flags == '0 && cmp_a_q == '0 && cmp_b_q == '0));

   // R2
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_wr) |=> $stable(count));

   // R13
   a_r13_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a || match_b || bottom) |-> tick_en);

   // R3
   a_r3_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (free_code && tick_en && !cnt_wr && count == '1) |=> (count == '0 && flags[0]));

   // R4
   a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 4'h4 && tick_en && !cnt_wr && count == cmp_a_q) |=> (count == '0 && flags[1]));

   // R9
   a_r9_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (known_top_pwm && !(tick_en && !cnt_wr && count == chk_top)) |=> $stable(cmp_a_q));

   // R11
   a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == $past(cnt_wdata)));

   // R11
   a_r11_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |-> !(match_a || match_b || bottom));

   // R12
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (kept != 3'b000) |=> ((flags & $past(kept)) == $past(kept)));

endmodule

bind pwm_timer16 pwm_timer16_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pwm_timer16_test.sv
`timescale 1ns/1ps
module pwm_timer16_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [3:0]  mode_sel = 4'h0;
   logic        cnt_wr = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic        cmpa_wr = 1'b0;
   logic [15:0] cmpa_wdata = '0;
   logic        cmpb_wr = 1'b0;
   logic [15:0] cmpb_wdata = '0;
   logic        capt_wr = 1'b0;
   logic [15:0] capt_wdata = '0;
   logic [2:0]  flag_clr = '0;
   logic [15:0] count, cmp_a_q, cmp_b_q;
   logic        match_a, match_b, bottom;
   logic [2:0]  flags;

   always #4 clk = ~clk;

   pwm_timer16 uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
      .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
      .capt_wr(capt_wr), .capt_wdata(capt_wdata),
      .flag_clr(flag_clr),
      .count(count), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q),
      .match_a(match_a), .match_b(match_b), .bottom(bottom), .flags(flags)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;
   bit    rand_en = 1'b0;
   logic [7:0] lfsr = 8'h5A;

   // reference state
   int       m_cnt = 0, m_a = 0, m_abuf = 0, m_b = 0, m_cap = 0;
   logic [2:0] m_flags = '0;

   function automatic bit is_slope(input logic [3:0] md);
      return md inside {4'h5, 4'h6, 4'h7, 4'hE, 4'hF};
   endfunction

   function automatic bit is_clear(input logic [3:0] md);
      return md == 4'h4 || md == 4'hC;
   endfunction

   function automatic int fixed_mask(input logic [3:0] md);
      case (md)
         4'h5: return 32'h00FF;
         4'h6: return 32'h01FF;
         4'h7: return 32'h03FF;
         default: return 32'hFFFF;
      endcase
   endfunction

   function automatic int ref_top(input logic [3:0] md);
      case (md)
         4'h4, 4'hF: return m_a;
         4'hC, 4'hE: return m_cap;
         default:    return fixed_mask(md);
      endcase
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic tick();
      int top, nc, na, nbuf, nb, ncap, v;
      bit en, hit;
      logic [2:0] setv;
      #1;
      top = ref_top(mode_sel);
      en  = tick_en && !cnt_wr;
      hit = en && (m_cnt == top);
      chk("count",   32'(count),   32'(m_cnt));
      chk("cmp_a_q", 32'(cmp_a_q), 32'(m_a));
      chk("cmp_b_q", 32'(cmp_b_q), 32'(m_b));
      chk("match_a", 32'(match_a), 32'(en && m_cnt == m_a));
      chk("match_b", 32'(match_b), 32'(en && m_cnt == m_b));
      chk("bottom",  32'(bottom),  32'(en && m_cnt == 0));
      chk("flags",   32'(flags),   32'(m_flags));
      na = m_a; nbuf = m_abuf; nb = m_b; ncap = m_cap; nc = m_cnt;
      if (cnt_wr) nc = int'(cnt_wdata);
      else if (tick_en) nc = ((is_slope(mode_sel) || is_clear(mode_sel)) && hit) ? 0 : ((m_cnt + 1) & 32'hFFFF);
      setv[0] = en && (is_slope(mode_sel) ? hit : (m_cnt == 32'hFFFF));
      setv[1] = en && (m_cnt == m_a);
      setv[2] = hit && (mode_sel == 4'hC || mode_sel == 4'hE);
      if (hit && is_slope(mode_sel)) na = m_abuf;
      if (cmpa_wr) begin
         v = int'(cmpa_wdata) & fixed_mask(mode_sel);
         nbuf = v;
         if (!is_slope(mode_sel)) na = v;
      end
      if (cmpb_wr) nb = int'(cmpb_wdata) & fixed_mask(mode_sel);
      if (capt_wr) ncap = int'(capt_wdata);
      @(posedge clk);
      m_cnt = nc; m_a = na; m_abuf = nbuf; m_b = nb; m_cap = ncap;
      m_flags = (m_flags & ~flag_clr) | setv;
      @(negedge clk);
      cnt_wr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0; capt_wr = 1'b0; flag_clr = '0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = rand_en ? (lfsr[0] | lfsr[3]) : 1'b1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         tick();
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL %s watchdog act=timeout exp=finish", cur_req);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, then R2: idle while the enable is low
      repeat (3) @(negedge clk);
      tick();
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R2";
      tick_en = 1'b0;
      for (int i = 0; i < 6; i++) tick();

      // R3: free-running wrap in mode 0
      cur_req = "R3";
      mode_sel = 4'h0;
      cnt_wr = 1'b1; cnt_wdata = 16'hFFF0;
      cmpb_wr = 1'b1; cmpb_wdata = 16'hFFF8;
      run(40);
      // R12: clear the overflow flag in the cycle it sets again -> set wins
      cur_req = "R12";
      cnt_wr = 1'b1; cnt_wdata = 16'hFFFE;
      run(1);
      tick_en = 1'b1; tick();
      flag_clr = 3'b001; tick_en = 1'b1; tick();
      flag_clr = 3'b111; run(3);
      // R3: reserved code acts as free-running
      cur_req = "R3";
      mode_sel = 4'h9;
      cnt_wr = 1'b1; cnt_wdata = 16'hFFF8;
      run(30);

      // R4: CTC on compare A with gated enable
      cur_req = "R4";
      mode_sel = 4'h4;
      flag_clr = 3'b111;
      cmpa_wr = 1'b1; cmpa_wdata = 16'h000A;
      cnt_wr = 1'b1; cnt_wdata = 16'h0000;
      cmpb_wr = 1'b1; cmpb_wdata = 16'h0005;
      rand_en = 1'b1;
      run(80);
      // R11: a counter write onto the match value suppresses the match
      cur_req = "R11";
      cnt_wr = 1'b1; cnt_wdata = 16'h000A;
      rand_en = 1'b0;
      run(1);
      cnt_wr = 1'b1; cnt_wdata = 16'h0005; tick_en = 1'b0; tick();
      run(20);

      // R5: CTC on the capture register
      cur_req = "R5";
      mode_sel = 4'hC;
      capt_wr = 1'b1; capt_wdata = 16'h0007;
      rand_en = 1'b1;
      run(50);
      flag_clr = 3'b111; run(10);
      rand_en = 1'b0;

      // R6: TOP lowered below the count -> runs through 0xFFFF
      cur_req = "R6";
      mode_sel = 4'h4;
      flag_clr = 3'b111;
      cmpa_wr = 1'b1; cmpa_wdata = 16'h0020;
      cnt_wr = 1'b1; cnt_wdata = 16'h0030;
      run(65560);

      // R7: fixed tops, with R13 compare B strobe
      cur_req = "R7";
      mode_sel = 4'h5;
      cnt_wr = 1'b1; cnt_wdata = 16'h0000;
      cmpb_wr = 1'b1; cmpb_wdata = 16'h0080;
      run(600);
      mode_sel = 4'h6; flag_clr = 3'b111;
      run(1100);
      mode_sel = 4'h7; flag_clr = 3'b111;
      rand_en = 1'b1;
      run(2400);
      rand_en = 1'b0;

      // R10: masking of written compare values in 8-bit fixed mode
      cur_req = "R10";
      mode_sel = 4'h5;
      cnt_wr = 1'b1; cnt_wdata = 16'h0000;
      cmpa_wr = 1'b1; cmpa_wdata = 16'h1234;
      cmpb_wr = 1'b1; cmpb_wdata = 16'hABCD;
      run(600);

      // R8: TOP from capture register in mode 0xE
      cur_req = "R8";
      mode_sel = 4'hE;
      flag_clr = 3'b111;
      capt_wr = 1'b1; capt_wdata = 16'h0030;
      cnt_wr = 1'b1; cnt_wdata = 16'h0000;
      run(150);
      // R8: TOP from compare A in mode 0xF (load A directly in mode 0 first)
      mode_sel = 4'h0;
      cmpa_wr = 1'b1; cmpa_wdata = 16'h0020;
      cnt_wr = 1'b1; cnt_wdata = 16'h0000;
      run(1);
      mode_sel = 4'hF; flag_clr = 3'b111;
      run(70);

      // R9: buffered write mid-period takes effect only at TOP
      cur_req = "R9";
      cmpa_wr = 1'b1; cmpa_wdata = 16'h0028;
      run(100);
      rand_en = 1'b1;
      cmpa_wr = 1'b1; cmpa_wdata = 16'h0012;
      run(150);
      rand_en = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule